// File: doc/BRIEF.md
# Cascaded 32-bit General-Purpose Timer

This block holds two 16-bit counters that software programs over a small 16-bit register bus. Each counter has its own control, count and compare registers. Both run from a base tick that a divide-by-four prescaler derives from one of two reference tick inputs. A static configuration pin selects which reference is used. The fast counter counts base ticks. The slow counter can count base ticks as well, or it can be set to step once each time the fast counter wraps. In that setting the pair forms a free-running 32-bit counter, with the slow counter as the upper half.

Software reads the 32-bit value as three reads: the upper half, the lower half, then the upper half again. When the two upper readings match, the three reads form a coherent value. When they differ, software repeats the sequence. The whole design runs on one clock. The reference inputs are single-cycle tick enables in that clock domain.

Top module: `cascade_timer32`

## Requirements
- R1: A control word stores continuous mode (bit 0), cascade select (bit 3) and retrigger (bit 5) on every write. The enable bit (bit 15) changes only when the write-qualifier bit (bit 14) is set in the same word. A control read returns enable, retrigger, cascade select and continuous mode in those positions, and returns 0 in all other bits, including bit 14.
- R2: The compare registers can be written and read back. In the address map, address bit 2 selects the counter (0 is the slow/upper counter, 1 is the fast/lower counter), and address bits 1:0 select the register (0 control, 1 count, 2 compare). Register select 3 reads as 0.
- R3: A base tick occurs on every fourth tick of the selected reference. `cfg_ref_sel` = 0 selects `ref_tick_a` and 1 selects `ref_tick_b`. The reference that is not selected has no effect.
- R4: An enabled counter steps by one on each tick. A disabled counter holds its count.
- R5: With compare value M, a counter runs 0 to M-1 and then wraps to 0. M = 0 gives the full 65536-count period, wrapping from 0xFFFF to 0.
- R6: When continuous mode is clear, the counter clears its enable at the wrap, and its count rests at 0.
- R7: With cascade select set, the slow counter steps in the same cycle that the enabled fast counter wraps, and at no other time. With cascade select clear, it steps on base ticks.
- R8: A count write presets the counter. The write wins over a step in the same cycle.
- R9: A high, low, high read sequence with equal high readings returns a coherent 32-bit value. A sequence that straddles a carry shows unequal high readings.
- R10: After reset, every register reads 0 and the prescaler phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ref_sel | input | 1 | Static reference choice (0: a, 1: b) |
| ref_tick_a | input | 1 | Reference tick enable, source a |
| ref_tick_b | input | 1 | Reference tick enable, source b |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |

## Verification
The hardest case to reach from the ports is a read sequence that straddles a carry from the lower half into the upper half. A natural wrap comes only once every 65536 base ticks, so waiting for one is impractical. The bench instead presets the lower count to 0xFFFF just before each three-read sequence. It shifts the preset through all four phases of the prescaler, so that the carry lands between the two upper reads in some sequences and outside them in others. A count write issued in each prescaler phase also exercises the case where a preset and a step fall in the same cycle.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int NUM_TMR = 2;
    localparam int PRE_DIV = 4;

    // control word bit positions
    localparam int CB_EN   = 15;
    localparam int CB_WQ   = 14;
    localparam int CB_RTG  = 5;
    localparam int CB_PSC  = 3;
    localparam int CB_CONT = 0;

    // counter indices: slow counter is the upper half
    localparam int T_SLOW = 0;
    localparam int T_FAST = 1;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_MAX   = 2'd2,
        SEL_RSVD  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic rtg;
        logic psc;
        logic cont;
    } tmr_ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_to_word(tmr_ctrl_t c);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[CB_EN]   = c.en;
        w[CB_RTG]  = c.rtg;
        w[CB_PSC]  = c.psc;
        w[CB_CONT] = c.cont;
        return w;
    endfunction

    function automatic tmr_ctrl_t ctrl_apply_write(tmr_ctrl_t cur, logic [DATA_W-1:0] w);
        tmr_ctrl_t n;
        n      = cur;
        n.rtg  = w[CB_RTG];
        n.psc  = w[CB_PSC];
        n.cont = w[CB_CONT];
        if (w[CB_WQ]) begin
            n.en = w[CB_EN];
        end
        return n;
    endfunction

    // last count value before the wrap; compare 0 gives all ones
    function automatic logic [DATA_W-1:0] last_count(logic [DATA_W-1:0] m);
        return m - 1'b1;
    endfunction

endpackage

// File: rtl/gpt_refdiv.sv
module gpt_refdiv
    import gpt_pkg::*;
#(
    parameter int DIV = PRE_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_sel,
    input  logic tick_a,
    input  logic tick_b,
    output logic base_tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;
    logic          sel_tick;

    assign sel_tick  = ref_sel ? tick_b : tick_a;
    assign base_tick = sel_tick && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (sel_tick) begin
            phase_q <= base_tick ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/gpt_core.sv
module gpt_core
    import gpt_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_ctrl,
    input  logic         wr_count,
    input  logic         wr_max,
    input  logic [W-1:0] wdata,
    input  logic         tick,
    output tmr_ctrl_t    ctrl_o,
    output logic [W-1:0] count_o,
    output logic [W-1:0] max_o,
    output logic         wrap_o
);
    tmr_ctrl_t    ctrl_q, ctrl_nxt;
    logic [W-1:0] count_q, max_q;
    logic         step, at_last;

    assign step    = ctrl_q.en && tick;
    assign at_last = (count_q == last_count(max_q));
    assign wrap_o  = step && at_last;

    always_comb begin
        ctrl_nxt = ctrl_q;
        if (wrap_o && !ctrl_q.cont) begin
            ctrl_nxt.en = 1'b0;
        end
        if (wr_ctrl) begin
            ctrl_nxt = ctrl_apply_write(ctrl_nxt, wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            count_q <= '0;
            max_q   <= '0;
        end else begin
            ctrl_q <= ctrl_nxt;
            if (wr_count) begin
                count_q <= wdata;
            end else if (step) begin
                count_q <= at_last ? '0 : count_q + 1'b1;
            end
            if (wr_max) begin
                max_q <= wdata;
            end
        end
    end

    assign ctrl_o  = ctrl_q;
    assign count_o = count_q;
    assign max_o   = max_q;

endmodule

// File: rtl/cascade_timer32.sv
module cascade_timer32
    import gpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_ref_sel,
    input  logic              ref_tick_a,
    input  logic              ref_tick_b,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              base_tick;
    tmr_ctrl_t         ctrl_q [NUM_TMR];
    logic [DATA_W-1:0] cnt_q  [NUM_TMR];
    logic [DATA_W-1:0] max_q  [NUM_TMR];
    logic              wrap   [NUM_TMR];
    logic              tick   [NUM_TMR];

    logic     tsel;
    reg_sel_e rsel;

    assign tsel = bus_addr[ADDR_W-1];
    assign rsel = reg_sel_e'(bus_addr[1:0]);

    gpt_refdiv #(.DIV(PRE_DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .ref_sel   (cfg_ref_sel),
        .tick_a    (ref_tick_a),
        .tick_b    (ref_tick_b),
        .base_tick (base_tick)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        logic hit;
        assign hit = bus_wr && (tsel == 1'(g));

        if (g == T_SLOW) begin : g_casc
            assign tick[g] = ctrl_q[g].psc ? wrap[T_FAST] : base_tick;
        end else begin : g_base
            assign tick[g] = base_tick;
        end

        gpt_core #(.W(DATA_W)) u_core (
            .clk      (clk),
            .rst      (rst),
            .wr_ctrl  (hit && (rsel == SEL_CTRL)),
            .wr_count (hit && (rsel == SEL_COUNT)),
            .wr_max   (hit && (rsel == SEL_MAX)),
            .wdata    (bus_wdata),
            .tick     (tick[g]),
            .ctrl_o   (ctrl_q[g]),
            .count_o  (cnt_q[g]),
            .max_o    (max_q[g]),
            .wrap_o   (wrap[g])
        );
    end

    always_comb begin
        unique case (rsel)
            SEL_CTRL:  bus_rdata = ctrl_to_word(ctrl_q[tsel]);
            SEL_COUNT: bus_rdata = cnt_q[tsel];
            SEL_MAX:   bus_rdata = max_q[tsel];
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cascade_timer32_chk.sv
module cascade_timer32_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_ref_sel,
    input logic        ref_tick_a,
    input logic        ref_tick_b,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        base_tick,
    input logic [15:0] hi_cnt,
    input logic [15:0] lo_cnt,
    input logic        hi_en,
    input logic        hi_psc,
    input logic        lo_en,
    input logic        lo_cont,
    input logic        lo_wrap
);
    logic wr_lo_cnt, wr_hi_cnt, wr_lo_ctrl;
    assign wr_lo_cnt  = bus_wr && (bus_addr == 3'd5);
    assign wr_hi_cnt  = bus_wr && (bus_addr == 3'd1);
    assign wr_lo_ctrl = bus_wr && (bus_addr == 3'd4);

    // R3
    base_src_chk: assert property (@(posedge clk) disable iff (rst)
        base_tick |-> (cfg_ref_sel ? ref_tick_b : ref_tick_a));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!lo_en && !wr_lo_cnt) |=> $stable(lo_cnt));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_wrap && !wr_lo_cnt) |=> (lo_cnt == 16'd0));

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_wrap && !lo_cont && !wr_lo_ctrl) |=> !lo_en);

    // R7
    cascade_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_en && hi_psc && !lo_wrap && !wr_hi_cnt) |=> $stable(hi_cnt));

    // R7
    cascade_step_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_en && hi_psc && lo_wrap && !wr_hi_cnt) |=> (hi_cnt == $past(hi_cnt) + 16'd1));

    // R8
    preset_chk: assert property (@(posedge clk) disable iff (rst)
        wr_lo_cnt |=> (lo_cnt == $past(bus_wdata)));

endmodule

bind cascade_timer32 cascade_timer32_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_ref_sel (cfg_ref_sel),
    .ref_tick_a  (ref_tick_a),
    .ref_tick_b  (ref_tick_b),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .base_tick   (base_tick),
    .hi_cnt      (cnt_q[0]),
    .lo_cnt      (cnt_q[1]),
    .hi_en       (ctrl_q[0].en),
    .hi_psc      (ctrl_q[0].psc),
    .lo_en       (ctrl_q[1].en),
    .lo_cont     (ctrl_q[1].cont),
    .lo_wrap     (wrap[1])
);

// File: tb/tb_cascade_timer32.sv
module tb_cascade_timer32;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_ref_sel = 1'b0;
    logic        ref_tick_a = 1'b0;
    logic        ref_tick_b = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;

    cascade_timer32 dut (
        .clk(clk), .rst(rst), .cfg_ref_sel(cfg_ref_sel),
        .ref_tick_a(ref_tick_a), .ref_tick_b(ref_tick_b),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    always #10 clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    string tag = "R10";
    bit    ta = 1'b0;
    bit    tb = 1'b0;

    // behavioural reference: index 0 = upper (slow), 1 = lower (fast)
    int m_div;
    int m_cnt [2];
    int m_max [2];
    bit m_en [2], m_cont [2], m_psc [2], m_rtg [2];

    always @(posedge clk) begin
        bit rt, base;
        bit inc [2];
        bit term [2];
        int idx;
        if (rst) begin
            m_div = 0;
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_max[i] = 0;
                m_en[i] = 0; m_cont[i] = 0; m_psc[i] = 0; m_rtg[i] = 0;
            end
        end else begin
            rt   = cfg_ref_sel ? ref_tick_b : ref_tick_a;
            base = rt && (m_div == 3);
            if (rt) m_div = (m_div + 1) % 4;
            inc[1]  = m_en[1] && base;
            term[1] = inc[1] && (m_cnt[1] == ((m_max[1] + 65535) % 65536));
            inc[0]  = m_en[0] && (m_psc[0] ? term[1] : base);
            term[0] = inc[0] && (m_cnt[0] == ((m_max[0] + 65535) % 65536));
            for (int i = 0; i < 2; i++) begin
                if (inc[i]) m_cnt[i] = term[i] ? 0 : m_cnt[i] + 1;
                if (term[i] && !m_cont[i]) m_en[i] = 0;
            end
            if (bus_wr && bus_addr[1:0] != 2'd3) begin
                idx = bus_addr[2] ? 1 : 0;
                case (bus_addr[1:0])
                    2'd0: begin
                        m_cont[idx] = bus_wdata[0];
                        m_psc[idx]  = bus_wdata[3];
                        m_rtg[idx]  = bus_wdata[5];
                        if (bus_wdata[14]) m_en[idx] = bus_wdata[15];
                    end
                    2'd1: m_cnt[idx] = bus_wdata;
                    default: m_max[idx] = bus_wdata;
                endcase
            end
        end
    end

    function automatic int m_read(logic [2:0] a);
        int i;
        i = a[2] ? 1 : 0;
        case (a[1:0])
            2'd0: return (int'(m_en[i]) << 15) | (int'(m_rtg[i]) << 5) |
                         (int'(m_psc[i]) << 3) | int'(m_cont[i]);
            2'd1: return m_cnt[i];
            2'd2: return m_max[i];
            default: return 0;
        endcase
    endfunction

    task automatic chk(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic cyc(bit wr, logic [2:0] a, logic [15:0] d, output logic [15:0] rd);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        ref_tick_a = ta; ref_tick_b = tb;
        #5;
        rd = bus_rdata;
        chk(tag, int'(rd), m_read(a));
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        logic [15:0] x;
        cyc(1'b1, a, d, x);
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] v);
        cyc(1'b0, a, 16'd0, v);
    endtask

    task automatic run(logic [2:0] a, int n);
        logic [15:0] x;
        for (int i = 0; i < n; i++) rd(a, x);
    endtask

    task automatic do_reset(bit sel);
        @(negedge clk);
        rst = 1'b1; bus_wr = 1'b0; cfg_ref_sel = sel;
        ref_tick_a = 1'b0; ref_tick_b = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [15:0] v, v2, h1, lo, h2, prev, top;
        int retries, good;
        bit saw;

        // R10: reset state
        do_reset(1'b0);
        tag = "R10";
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R10 reset value", int'(v), 0);
        end

        // R3: divide by four on reference a
        tag = "R3";
        wr(3'd4, 16'hC001);
        ta = 1'b1; run(3'd5, 3);
        ta = 1'b0; rd(3'd5, v);
        chk("R3 three ref ticks give no step", int'(v), 0);
        ta = 1'b1; run(3'd5, 1);
        ta = 1'b0; rd(3'd5, v);
        chk("R3 fourth ref tick steps", int'(v), 1);

        // R1: enable gated by qualifier
        tag = "R1";
        do_reset(1'b0);
        wr(3'd4, 16'h8001); rd(3'd4, v);
        chk("R1 enable without qualifier", int'(v), 16'h0001);
        wr(3'd4, 16'hC001); rd(3'd4, v);
        chk("R1 enable with qualifier", int'(v), 16'h8001);
        wr(3'd4, 16'h0029); rd(3'd4, v);
        chk("R1 other bits update, enable kept", int'(v), 16'h8029);
        wr(3'd4, 16'h4000); rd(3'd4, v);
        chk("R1 qualified disable", int'(v), 16'h0000);

        // R2: compare registers and reserved slot
        tag = "R2";
        wr(3'd2, 16'h1234); rd(3'd2, v);
        chk("R2 slow compare readback", int'(v), 16'h1234);
        wr(3'd6, 16'h0005); rd(3'd6, v);
        chk("R2 fast compare readback", int'(v), 16'h0005);
        wr(3'd3, 16'hFFFF); rd(3'd3, v);
        chk("R2 reserved reads zero", int'(v), 0);

        // R5: full period wrap with compare 0
        tag = "R5";
        ta = 1'b1;
        wr(3'd6, 16'h0000); wr(3'd5, 16'hFFFC); wr(3'd4, 16'hC001);
        saw = 1'b0; prev = 16'hFFFC;
        for (int i = 0; i < 40; i++) begin
            rd(3'd5, v);
            if (prev == 16'hFFFF && v == 16'h0000) saw = 1'b1;
            prev = v;
        end
        chk("R5 wrap from FFFF to 0", int'(saw), 1);
        wr(3'd6, 16'h0005); wr(3'd5, 16'h0000);
        top = 16'h0;
        for (int i = 0; i < 60; i++) begin
            rd(3'd5, v);
            if (v > top) top = v;
        end
        chk("R5 highest count is compare minus one", int'(top), 4);

        // R4: disabled counter holds
        tag = "R4";
        wr(3'd4, 16'h4001); rd(3'd5, v);
        run(3'd5, 20);
        rd(3'd5, v2);
        chk("R4 disabled hold", int'(v2), int'(v));

        // R6: one-shot stops at the wrap
        tag = "R6";
        wr(3'd6, 16'h0003); wr(3'd5, 16'h0000); wr(3'd4, 16'hC000);
        run(3'd5, 30);
        rd(3'd4, v);
        chk("R6 enable cleared", int'(v), 0);
        rd(3'd5, v);
        chk("R6 count rests at 0", int'(v), 0);

        // R7: cascade and plain base-tick mode on the slow counter
        tag = "R7";
        wr(3'd1, 16'h0000); wr(3'd2, 16'h0000);
        wr(3'd0, 16'hC009); wr(3'd4, 16'hC001);
        run(3'd1, 100);
        rd(3'd1, v);
        chk("R7 cascade count", int'(v), m_cnt[0]);
        wr(3'd0, 16'hC001);
        run(3'd1, 24);

        // R8: preset wins, in every prescaler phase
        tag = "R8";
        wr(3'd6, 16'h0000); wr(3'd4, 16'hC001);
        for (int k = 0; k < 4; k++) begin
            wr(3'd5, 16'h0100 + 16'(k * 16));
            rd(3'd5, v);
            chk("R8 preset value", int'(v), 16'h0100 + k * 16);
            rd(3'd5, v);
        end

        // R9: high/low/high reads straddling a carry
        tag = "R9";
        wr(3'd1, 16'h0007); wr(3'd0, 16'hC009);
        retries = 0; good = 0;
        for (int k = 0; k < 8; k++) begin
            run(3'd5, k % 4);
            wr(3'd5, 16'hFFFF);
            rd(3'd1, h1); rd(3'd5, lo); rd(3'd1, h2);
            if (h1 == h2) begin
                good++;
                chk("R9 coherent low half", int'(lo), 16'hFFFF);
            end else begin
                retries++;
                chk("R9 straddle carries by one", int'(h2), int'(h1) + 1);
            end
        end
        chk("R9 some sequence straddled", int'(retries > 0), 1);
        chk("R9 some sequence coherent", int'(good > 0), 1);

        // R3: reference b selected, a ignored
        tag = "R3";
        do_reset(1'b1);
        ta = 1'b0; tb = 1'b0;
        wr(3'd4, 16'hC001);
        ta = 1'b1; run(3'd5, 8);
        ta = 1'b0; rd(3'd5, v);
        chk("R3 unselected reference ignored", int'(v), 0);
        tb = 1'b1; run(3'd5, 4);
        tb = 1'b0; rd(3'd5, v);
        chk("R3 selected reference b steps", int'(v), 1);

        summary();
    end

endmodule